// File: doc/BRIEF.md
# ModR/M Effective Address Stage

This block is a single registered pipeline stage that turns a decoded operand-addressing byte into a memory address. Its inputs are the addressing byte, an optional scale/index/base byte, a raw displacement word, a flag that selects 16-bit or 32-bit addressing, and the eight general registers packed into one vector. One cycle after a valid strobe it presents one of two results. For a register operand it gives the register number. For a memory operand it gives the computed effective address and the default segment, DS or SS.

The addressing byte is split into mode (bits 7:6), a middle field (bits 5:3) that this block does not use, and register/memory (bits 2:0). The optional second byte is split into scale (bits 7:6), index (bits 5:3) and base (bits 2:0). The registers are numbered 0 to 7 in this order: AX, CX, DX, BX, SP, BP, SI, DI. Register n occupies bits [32n+31:32n] of the register vector. A 16-bit address uses only the low half of each register.

Top module: `ea_calc_stage`

## Requirements
- R1: Mode 11 gives a register operand. `opnd_is_reg`=1, `opnd_reg` equals bits 2:0 of the addressing byte, `eff_addr`=0 and `seg_is_ss`=0. Any other mode gives `opnd_is_reg`=0.
- R2: In 16-bit mode, codes 0 to 7 form these addresses: BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. A displacement is added where the mode calls for one.
- R3: In 16-bit mode, mode 00 with code 110 uses no register. The address is the low 16 bits of `disp`.
- R4: Mode 01 adds `disp[7:0]` sign-extended to the address width. Mode 10 adds `disp[15:0]` in 16-bit mode and `disp[31:0]` in 32-bit mode.
- R5: In 16-bit mode, `seg_is_ss`=1 whenever BP is part of the address. Otherwise it is 0.
- R6: In 32-bit mode, without a second byte (any code except 100), the base is the register named by the code. The exception is mode 00 with code 101, which gives `disp[31:0]` alone.
- R7: In 32-bit mode, code 100 brings in the second byte. The address is base + (index << scale) + displacement. Index code 100 adds no index.
- R8: In the second byte, base code 101 with mode 00 has no base and adds `disp[31:0]`. With mode 01 or 10, base code 101 uses BP plus the mode's displacement.
- R9: In 32-bit mode, `seg_is_ss`=1 exactly when the base register in use is SP or BP. It is 0 when there is no base.
- R10: 16-bit addresses wrap modulo 65536, and `eff_addr[31:16]` is then 0. 32-bit addresses wrap modulo 2^32.
- R11: The outputs are loaded on the clock edge that samples `in_valid`=1. `out_valid` is high in the following cycle only. The outputs hold their values until the next strobe.
- R12: Synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: sample the operand inputs |
| addr32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit |
| modrm | input | 8 | Addressing byte |
| sib | input | 8 | Scale/index/base byte |
| disp | input | 32 | Raw displacement; the low 8, 16 or 32 bits are used |
| reg_file | input | 256 | Eight 32-bit registers, register 0 in the low bits |
| out_valid | output | 1 | Result loaded in the previous cycle |
| opnd_is_reg | output | 1 | Operand is a register |
| opnd_reg | output | 3 | Register number for a register operand |
| seg_is_ss | output | 1 | Default segment: 1 = SS, 0 = DS |
| eff_addr | output | 32 | Effective address |

## Verification
Address wrap and segment selection come from the same decode in the same cycle. The bench provokes both together: in 16-bit mode it uses BP+SI with a large displacement, so the sum overflows 16 bits while BP forces SS. In 32-bit mode it uses a scaled index, a byte displacement and the BP-base special case in one strobe. Each such strobe is judged on all result fields at once, against values worked out by hand. The bench also checks that a strobe is followed by idle cycles with changed inputs and the held result stays the same.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 8;
    localparam int RIDX   = $clog2(NREG);
    localparam int HLEN   = XLEN / 2;

    localparam logic [RIDX-1:0] R_BX = 3'd3;
    localparam logic [RIDX-1:0] R_SP = 3'd4;
    localparam logic [RIDX-1:0] R_BP = 3'd5;
    localparam logic [RIDX-1:0] R_SI = 3'd6;
    localparam logic [RIDX-1:0] R_DI = 3'd7;

    typedef enum logic [1:0] {
        MD_NODISP = 2'b00,
        MD_DISP8  = 2'b01,
        MD_DISPW  = 2'b10,
        MD_REG    = 2'b11
    } mode_e;

    typedef enum logic {
        SEG_DS = 1'b0,
        SEG_SS = 1'b1
    } seg_e;

    typedef logic [NREG-1:0][XLEN-1:0] regs_t;

    typedef struct packed {
        logic            is_reg;
        logic [RIDX-1:0] idx;
        seg_e            seg;
        logic [XLEN-1:0] ea;
    } ea_res_t;

    function automatic logic [XLEN-1:0] sext8(input logic [7:0] b);
        return {{(XLEN-8){b[7]}}, b};
    endfunction
endpackage

// File: rtl/ea16_calc.sv
module ea16_calc
    import ea_pkg::*;
(
    input  mode_e                mode,
    input  logic [RIDX-1:0]      rm,
    input  logic [HLEN-1:0]      disp,
    input  regs_t                regs,
    output logic [HLEN-1:0]      ea,
    output seg_e                 seg
);
    logic [HLEN-1:0] term_a, term_b, term_d;
    logic            uses_bp;

    always_comb begin
        term_a  = '0;
        term_b  = '0;
        uses_bp = 1'b0;
        case (rm)
            3'd0: begin term_a = regs[R_BX][HLEN-1:0]; term_b = regs[R_SI][HLEN-1:0]; end
            3'd1: begin term_a = regs[R_BX][HLEN-1:0]; term_b = regs[R_DI][HLEN-1:0]; end
            3'd2: begin term_a = regs[R_BP][HLEN-1:0]; term_b = regs[R_SI][HLEN-1:0]; uses_bp = 1'b1; end
            3'd3: begin term_a = regs[R_BP][HLEN-1:0]; term_b = regs[R_DI][HLEN-1:0]; uses_bp = 1'b1; end
            3'd4: term_a = regs[R_SI][HLEN-1:0];
            3'd5: term_a = regs[R_DI][HLEN-1:0];
            3'd6: begin
                if (mode != MD_NODISP) begin
                    term_a  = regs[R_BP][HLEN-1:0];
                    uses_bp = 1'b1;
                end
            end
            default: term_a = regs[R_BX][HLEN-1:0];
        endcase

        case (mode)
            MD_NODISP: term_d = (rm == 3'd6) ? disp : '0;
            MD_DISP8:  term_d = {{(HLEN-8){disp[7]}}, disp[7:0]};
            default:   term_d = disp;
        endcase

        ea  = term_a + term_b + term_d;
        seg = uses_bp ? SEG_SS : SEG_DS;
    end
endmodule

// File: rtl/ea32_calc.sv
module ea32_calc
    import ea_pkg::*;
(
    input  mode_e                mode,
    input  logic [RIDX-1:0]      rm,
    input  logic [7:0]           sib,
    input  logic [XLEN-1:0]      disp,
    input  regs_t                regs,
    output logic [XLEN-1:0]      ea,
    output seg_e                 seg
);
    logic            has_sib;
    logic [RIDX-1:0] base_code;
    logic [RIDX-1:0] index_code;
    logic [1:0]      scale;
    logic            no_base;
    logic [XLEN-1:0] base_v, index_v, disp_v;

    always_comb begin
        has_sib    = (rm == R_SP);
        base_code  = has_sib ? sib[2:0] : rm;
        index_code = sib[5:3];
        scale      = sib[7:6];
        no_base    = (mode == MD_NODISP) && (base_code == R_BP);

        base_v  = no_base ? '0 : regs[base_code];
        index_v = (has_sib && index_code != R_SP) ? (regs[index_code] << scale) : '0;

        case (mode)
            MD_NODISP: disp_v = no_base ? disp : '0;
            MD_DISP8:  disp_v = sext8(disp[7:0]);
            default:   disp_v = disp;
        endcase

        ea  = base_v + index_v + disp_v;
        seg = (!no_base && (base_code == R_SP || base_code == R_BP)) ? SEG_SS : SEG_DS;
    end
endmodule

// File: rtl/ea_calc_stage.sv
module ea_calc_stage
    import ea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 addr32,
    input  logic [7:0]           modrm,
    input  logic [7:0]           sib,
    input  logic [XLEN-1:0]      disp,
    input  logic [NREG*XLEN-1:0] reg_file,
    output logic                 out_valid,
    output logic                 opnd_is_reg,
    output logic [RIDX-1:0]      opnd_reg,
    output logic                 seg_is_ss,
    output logic [XLEN-1:0]      eff_addr
);
    regs_t           regs;
    mode_e           mode;
    logic [RIDX-1:0] rm;
    logic [HLEN-1:0] ea16;
    logic [XLEN-1:0] ea32;
    seg_e            seg16, seg32;
    ea_res_t         res_d, res_q;
    logic            valid_q;

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign regs[g] = reg_file[g*XLEN +: XLEN];
    end

    assign mode = mode_e'(modrm[7:6]);
    assign rm   = modrm[2:0];

    ea16_calc u_ea16 (
        .mode (mode),
        .rm   (rm),
        .disp (disp[HLEN-1:0]),
        .regs (regs),
        .ea   (ea16),
        .seg  (seg16)
    );

    ea32_calc u_ea32 (
        .mode (mode),
        .rm   (rm),
        .sib  (sib),
        .disp (disp),
        .regs (regs),
        .ea   (ea32),
        .seg  (seg32)
    );

    always_comb begin
        res_d = '0;
        if (mode == MD_REG) begin
            res_d.is_reg = 1'b1;
            res_d.idx    = rm;
            res_d.seg    = SEG_DS;
        end else if (addr32) begin
            res_d.ea  = ea32;
            res_d.seg = seg32;
        end else begin
            res_d.ea  = {{(XLEN-HLEN){1'b0}}, ea16};
            res_d.seg = seg16;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid   = valid_q;
    assign opnd_is_reg = res_q.is_reg;
    assign opnd_reg    = res_q.idx;
    assign seg_is_ss   = (res_q.seg == SEG_SS);
    assign eff_addr    = res_q.ea;

    AST_REG_OPERAND: assert property (@(posedge clk) disable iff (rst)
        in_valid && modrm[7:6] == 2'b11 |=> opnd_is_reg && opnd_reg == $past(modrm[2:0]) && eff_addr == '0 && !seg_is_ss); // R1
    AST_MEM_OPERAND: assert property (@(posedge clk) disable iff (rst)
        in_valid && modrm[7:6] != 2'b11 |=> !opnd_is_reg); // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_valid && !addr32 |=> eff_addr[XLEN-1:HLEN] == '0); // R10
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R11
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(eff_addr) && $stable(opnd_is_reg) && $stable(seg_is_ss) && $stable(opnd_reg)); // R11
endmodule

// File: tb/ea_calc_stage_tb.sv
module ea_calc_stage_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         addr32;
    logic [7:0]   modrm;
    logic [7:0]   sib;
    logic [31:0]  disp;
    logic [255:0] reg_file;
    logic         out_valid;
    logic         opnd_is_reg;
    logic [2:0]   opnd_reg;
    logic         seg_is_ss;
    logic [31:0]  eff_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ea_calc_stage u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .addr32(addr32),
        .modrm(modrm), .sib(sib), .disp(disp), .reg_file(reg_file),
        .out_valid(out_valid), .opnd_is_reg(opnd_is_reg), .opnd_reg(opnd_reg),
        .seg_is_ss(seg_is_ss), .eff_addr(eff_addr)
    );

    task automatic check(input string req, input logic v, input logic r, input logic [2:0] idx,
                         input logic ss, input logic [31:0] ea);
        n_checks++;
        if (out_valid !== v || opnd_is_reg !== r || opnd_reg !== idx || seg_is_ss !== ss || eff_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: got v=%b reg=%b idx=%0d ss=%b ea=%h, expected v=%b reg=%b idx=%0d ss=%b ea=%h",
                     req, out_valid, opnd_is_reg, opnd_reg, seg_is_ss, eff_addr, v, r, idx, ss, ea);
        end
    endtask

    // drive at negedge, capture at posedge, sample at following negedge
    task automatic apply(input string req, input logic a32, input logic [7:0] m, input logic [7:0] s,
                         input logic [31:0] d, input logic r, input logic [2:0] idx,
                         input logic ss, input logic [31:0] ea);
        @(negedge clk);
        in_valid = 1'b1; addr32 = a32; modrm = m; sib = s; disp = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, 1'b1, r, idx, ss, ea);
    endtask

    task automatic t_reset;
        check("R12 reset", 1'b0, 1'b0, 3'd0, 1'b0, 32'h0);
    endtask

    task automatic t_register;
        apply("R1 register operand", 1'b0, 8'hED, 8'h00, 32'h0, 1'b1, 3'd5, 1'b0, 32'h0);
        apply("R1 register operand 32", 1'b1, 8'hC2, 8'hFF, 32'h1234, 1'b1, 3'd2, 1'b0, 32'h0);
    endtask

    task automatic t_mode16;
        apply("R2 BX+SI", 1'b0, 8'h00, 8'h00, 32'h0, 1'b0, 3'd0, 1'b0, 32'h0000_3040);
        apply("R2 R5 BP+DI", 1'b0, 8'h03, 8'h00, 32'h0, 1'b0, 3'd0, 1'b1, 32'h0000_F080);
        apply("R2 BX", 1'b0, 8'h07, 8'h00, 32'h0, 1'b0, 3'd0, 1'b0, 32'h0000_3000);
        apply("R3 direct", 1'b0, 8'h06, 8'h00, 32'hFFFF_1234, 1'b0, 3'd0, 1'b0, 32'h0000_1234);
        apply("R4 R5 BP+disp8 neg", 1'b0, 8'h46, 8'h00, 32'h0000_00F0, 1'b0, 3'd0, 1'b1, 32'h0000_EFF0);
        apply("R10 R5 16-bit wrap", 1'b0, 8'h82, 8'h00, 32'hFFFF_2000, 1'b0, 3'd0, 1'b1, 32'h0000_1040);
    endtask

    task automatic t_mode32;
        apply("R6 EBX", 1'b1, 8'h03, 8'h00, 32'h0, 1'b0, 3'd0, 1'b0, 32'h1234_3000);
        apply("R6 disp32 only", 1'b1, 8'h05, 8'h00, 32'hDEAD_BEEF, 1'b0, 3'd0, 1'b0, 32'hDEAD_BEEF);
        apply("R6 R9 EBP+disp8", 1'b1, 8'h45, 8'h00, 32'h0000_0080, 1'b0, 3'd0, 1'b1, 32'h0000_EF80);
        apply("R4 EAX+disp32", 1'b1, 8'h80, 8'h00, 32'h0001_0000, 1'b0, 3'd0, 1'b0, 32'h0001_1000);
        apply("R10 32-bit wrap", 1'b1, 8'h80, 8'h00, 32'hFFFF_F000, 1'b0, 3'd0, 1'b0, 32'h0);
    endtask

    task automatic t_sib;
        apply("R7 EBX+ECX*4", 1'b1, 8'h04, 8'h8B, 32'h0, 1'b0, 3'd0, 1'b0, 32'h1234_3040);
        apply("R7 no index", 1'b1, 8'h04, 8'hE0, 32'h0, 1'b0, 3'd0, 1'b0, 32'h0000_1000);
        apply("R8 no base", 1'b1, 8'h04, 8'hF5, 32'h0000_0100, 1'b0, 3'd0, 1'b0, 32'h0000_0300);
        apply("R8 R9 EBP base", 1'b1, 8'h44, 8'hF5, 32'h0000_0010, 1'b0, 3'd0, 1'b1, 32'h0000_F210);
        apply("R9 ESP base", 1'b1, 8'h04, 8'h24, 32'h0, 1'b0, 3'd0, 1'b1, 32'h0000_7F00);
    endtask

    task automatic t_hold;
        apply("R11 strobe", 1'b0, 8'h02, 8'h00, 32'h0, 1'b0, 3'd0, 1'b1, 32'h0000_F040);
        modrm = 8'hC7; addr32 = 1'b1; disp = 32'h5555_5555;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 hold", 1'b0, 1'b0, 3'd0, 1'b1, 32'h0000_F040);
        end
    endtask

    initial begin
        reg_file = {32'h0000_0080, 32'h0000_0040, 32'h0000_F000, 32'h0000_7F00,
                    32'h1234_3000, 32'h0000_0200, 32'h0000_0010, 32'h0000_1000};
        rst = 1'b1; in_valid = 1'b0; addr32 = 1'b0; modrm = 8'h0; sib = 8'h0; disp = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_register();
        t_mode16();
        t_mode32();
        t_sib();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule